// File: doc/BRIEF.md
# Dual-Slope Meter Conversion Sequencer

This block sets the pace of a dual-slope measuring instrument. A free-running oscillator is its only clock. An internal divider produces a tick at a fraction of that rate. A cycle counter advances on each tick and wraps after a fixed number of ticks, which defines one conversion.

Near the end of every conversion an active-low latch strobe opens a window. Inside that window the running measurement count is copied into a display holding register. On the first tick of the window, the raw overrange and underrange conditions are captured into flags. The flags then stay fixed until the window of the next conversion opens. A latched overrange turns off the enables of the upper display digits.

Two asynchronous status lines, low battery and continuity, pass through two-stage synchronizers. They then drive annunciator bits and a continuity output. The measurement input has no handshake: the counter value is sampled at every tick inside the window, so the source only has to present a settled count during that window. The block never applies back-pressure. A one-oscillator-cycle `cycle_end` pulse marks the last count of each conversion.

Top module: `conv_sequencer`

## Requirements
- R1: The internal tick occurs once every DIV oscillator cycles, and one conversion lasts CYC_LEN ticks (CYC_LEN*DIV oscillator cycles). `cycle_end` is high for exactly one oscillator cycle, during the final tick of each conversion.
- R2: `latch_n` is low exactly while the cycle count lies in the last LATCH_LEN ticks of the conversion. It is high for all other counts, and it returns high at the edge where the count wraps.
- R3: `disp_value` takes the value of `meas_count` at every tick while `latch_n` is low. Outside that window, changes on `meas_count` have no effect on `disp_value`.
- R4: `ovr_out` and `udr_out` load `ovr_raw` and `udr_raw` at the clock edge where `latch_n` falls. They keep that value until the next such edge.
- R5: `digit_en` has one bit per digit, with bit i enabling digit i. While `ovr_out` is 1, bits BLANK_FIRST through BLANK_LAST (1 to 4 by default) are 0. Every other bit is always 1.
- R6: `ann_lowbat` equals `lowbat_in` as it was two oscillator edges earlier.
- R7: `cont_out` and `ann_cont` equal `cont_in` as it was two oscillator edges earlier.
- R8: A synchronous active-high `rst` clears the divider, the cycle count, `disp_value`, the flags and the synchronizers, and drives `latch_n` high. Counting restarts from count 0 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_count | input | MEAS_W | Running measurement count |
| ovr_raw | input | 1 | Raw overrange condition |
| udr_raw | input | 1 | Raw underrange condition |
| lowbat_in | input | 1 | Asynchronous low-battery status |
| cont_in | input | 1 | Asynchronous continuity comparator result |
| latch_n | output | 1 | Active-low latch/hold strobe |
| cycle_end | output | 1 | Pulse on the last count of each conversion |
| disp_value | output | MEAS_W | Display holding register |
| ovr_out | output | 1 | Latched overrange flag |
| udr_out | output | 1 | Latched underrange flag |
| digit_en | output | NUM_DIGITS | Per-digit display enables |
| cont_out | output | 1 | Synchronized continuity output |
| ann_lowbat | output | 1 | Low-battery annunciator bit |
| ann_cont | output | 1 | Continuity annunciator bit |

## Verification
The assertions check on every cycle that `cycle_end` is a single-cycle pulse inside the latch window and is followed by the strobe rising. They also check that `disp_value` stays stable while the strobe is high, that the flags move only at the strobe's falling edge, and that the annunciators trail their inputs by two edges. Some properties need arithmetic over the whole run, and only the bench's sweeps can show them. These are the exact conversion length, the exact width and position of the window, which measurement value ends up held, which raw flag values are captured, and the digit blanking pattern. The bench sweeps several full conversions of a reduced configuration with the inputs changing continuously, with a reset in the middle of a conversion.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  // Captured range status of one conversion.
  typedef struct packed {
    logic ovr;
    logic udr;
  } range_flags_t;
endpackage

// File: rtl/cs_tick_gen.sv
module cs_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] TOP = W'(DIV - 1);

  logic [W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)               phase_q <= '0;
    else if (phase_q == TOP) phase_q <= '0;
    else                   phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == TOP);
endmodule

// File: rtl/cs_cycle_ctr.sv
module cs_cycle_ctr #(
  parameter int CYC_LEN   = 30000,
  parameter int LATCH_LEN = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic latch_n,
  output logic cycle_end,
  output logic latch_fall
);
  localparam int CNT_W = $clog2(CYC_LEN);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(CYC_LEN - 1);
  localparam logic [CNT_W-1:0] WIN_START = CNT_W'(CYC_LEN - LATCH_LEN);
  localparam logic [CNT_W-1:0] PRE_WIN   = CNT_W'(CYC_LEN - LATCH_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             latch_n_q;

  assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      latch_n_q <= 1'b1;
    end else if (tick) begin
      cnt_q     <= cnt_nxt;
      latch_n_q <= (cnt_nxt < WIN_START);
    end
  end

  assign latch_n    = latch_n_q;
  assign cycle_end  = tick && (cnt_q == LAST);
  assign latch_fall = tick && (cnt_q == PRE_WIN);
endmodule

// File: rtl/cs_sync2.sv
module cs_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/cs_result_hold.sv
module cs_result_hold
  import conv_seq_pkg::*;
#(
  parameter int MEAS_W      = 16,
  parameter int NUM_DIGITS  = 5,
  parameter int BLANK_FIRST = 1,
  parameter int BLANK_LAST  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  latch_n,
  input  logic                  latch_fall,
  input  logic [MEAS_W-1:0]     meas,
  input  range_flags_t          raw_flags,
  output logic [MEAS_W-1:0]     hold,
  output range_flags_t          flags,
  output logic [NUM_DIGITS-1:0] dig_en
);
  logic [MEAS_W-1:0] hold_q;
  range_flags_t      flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      flags_q <= '0;
    end else begin
      if (tick && !latch_n) hold_q  <= meas;
      if (latch_fall)       flags_q <= raw_flags;
    end
  end

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    if (i >= BLANK_FIRST && i <= BLANK_LAST) begin : g_blankable
      assign dig_en[i] = !flags_q.ovr;
    end else begin : g_fixed
      assign dig_en[i] = 1'b1;
    end
  end

  assign hold  = hold_q;
  assign flags = flags_q;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int DIV         = 2,
  parameter int CYC_LEN     = 30000,
  parameter int LATCH_LEN   = 100,
  parameter int MEAS_W      = 16,
  parameter int NUM_DIGITS  = 5,
  parameter int BLANK_FIRST = 1,
  parameter int BLANK_LAST  = 4
) (
  input  logic                  osc_clk,
  input  logic                  rst,
  input  logic [MEAS_W-1:0]     meas_count,
  input  logic                  ovr_raw,
  input  logic                  udr_raw,
  input  logic                  lowbat_in,
  input  logic                  cont_in,
  output logic                  latch_n,
  output logic                  cycle_end,
  output logic [MEAS_W-1:0]     disp_value,
  output logic                  ovr_out,
  output logic                  udr_out,
  output logic [NUM_DIGITS-1:0] digit_en,
  output logic                  cont_out,
  output logic                  ann_lowbat,
  output logic                  ann_cont
);
  logic         tick;
  logic         latch_fall;
  range_flags_t raw_flags;
  range_flags_t flags;
  logic [1:0]   status_sync;

  cs_tick_gen #(.DIV(DIV)) tick_i (
    .clk (osc_clk),
    .rst (rst),
    .tick(tick)
  );

  cs_cycle_ctr #(.CYC_LEN(CYC_LEN), .LATCH_LEN(LATCH_LEN)) ctr_i (
    .clk       (osc_clk),
    .rst       (rst),
    .tick      (tick),
    .latch_n   (latch_n),
    .cycle_end (cycle_end),
    .latch_fall(latch_fall)
  );

  assign raw_flags.ovr = ovr_raw;
  assign raw_flags.udr = udr_raw;

  cs_result_hold #(
    .MEAS_W     (MEAS_W),
    .NUM_DIGITS (NUM_DIGITS),
    .BLANK_FIRST(BLANK_FIRST),
    .BLANK_LAST (BLANK_LAST)
  ) hold_i (
    .clk       (osc_clk),
    .rst       (rst),
    .tick      (tick),
    .latch_n   (latch_n),
    .latch_fall(latch_fall),
    .meas      (meas_count),
    .raw_flags (raw_flags),
    .hold      (disp_value),
    .flags     (flags),
    .dig_en    (digit_en)
  );

  cs_sync2 #(.W(2)) sync_i (
    .clk(osc_clk),
    .rst(rst),
    .d  ({cont_in, lowbat_in}),
    .q  (status_sync)
  );

  assign ovr_out    = flags.ovr;
  assign udr_out    = flags.udr;
  assign ann_lowbat = status_sync[0];
  assign cont_out   = status_sync[1];
  assign ann_cont   = status_sync[1];
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int MEAS_W = 16
) (
  input logic              osc_clk,
  input logic              rst,
  input logic              latch_n,
  input logic              cycle_end,
  input logic [MEAS_W-1:0] disp_value,
  input logic              ovr_out,
  input logic              udr_out,
  input logic              lowbat_in,
  input logic              cont_in,
  input logic              ann_lowbat,
  input logic              cont_out,
  input logic              ann_cont
);
  AST_END_SINGLE: assert property (@(posedge osc_clk) disable iff (rst)
    cycle_end |=> !cycle_end); // R1

  AST_END_IN_WINDOW: assert property (@(posedge osc_clk) disable iff (rst)
    cycle_end |-> !latch_n); // R2

  AST_LATCH_RISES_AT_WRAP: assert property (@(posedge osc_clk) disable iff (rst)
    cycle_end |=> latch_n); // R2

  AST_HOLD_STABLE_OUTSIDE: assert property (@(posedge osc_clk) disable iff (rst)
    latch_n |=> $stable(disp_value)); // R3

  AST_FLAGS_ONLY_AT_FALL: assert property (@(posedge osc_clk) disable iff (rst)
    (!$past(rst) && !$fell(latch_n)) |-> $stable({ovr_out, udr_out})); // R4

  AST_LOWBAT_TWO_EDGES: assert property (@(posedge osc_clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (ann_lowbat == $past(lowbat_in, 2))); // R6

  AST_CONT_TWO_EDGES: assert property (@(posedge osc_clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (cont_out == $past(cont_in, 2) && ann_cont == cont_out)); // R7
endmodule

bind conv_sequencer conv_sequencer_chk #(.MEAS_W(MEAS_W)) chk_i (
  .osc_clk   (osc_clk),
  .rst       (rst),
  .latch_n   (latch_n),
  .cycle_end (cycle_end),
  .disp_value(disp_value),
  .ovr_out   (ovr_out),
  .udr_out   (udr_out),
  .lowbat_in (lowbat_in),
  .cont_in   (cont_in),
  .ann_lowbat(ann_lowbat),
  .cont_out  (cont_out),
  .ann_cont  (ann_cont)
);

// File: tb/conv_sequencer_tb_top.sv
`timescale 1ns/1ps
module conv_sequencer_tb_top;
  localparam int DIV    = 2;
  localparam int CYC    = 40;
  localparam int LAT    = 5;
  localparam int MEAS_W = 16;
  localparam int ND     = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [MEAS_W-1:0] meas = '0;
  logic              ovr = 1'b0, udr = 1'b0, lowbat = 1'b0, cont = 1'b0;
  logic              latch_n, cycle_end, ovr_out, udr_out, cont_out, ann_lowbat, ann_cont;
  logic [MEAS_W-1:0] disp_value;
  logic [ND-1:0]     digit_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  conv_sequencer #(
    .DIV(DIV), .CYC_LEN(CYC), .LATCH_LEN(LAT), .MEAS_W(MEAS_W),
    .NUM_DIGITS(ND), .BLANK_FIRST(1), .BLANK_LAST(4)
  ) dut_i (
    .osc_clk(clk), .rst(rst), .meas_count(meas), .ovr_raw(ovr), .udr_raw(udr),
    .lowbat_in(lowbat), .cont_in(cont), .latch_n(latch_n), .cycle_end(cycle_end),
    .disp_value(disp_value), .ovr_out(ovr_out), .udr_out(udr_out),
    .digit_en(digit_en), .cont_out(cont_out), .ann_lowbat(ann_lowbat),
    .ann_cont(ann_cont)
  );

  // Reference built from the requirements: e counts oscillator edges since reset release.
  int                e = 0;
  logic [MEAS_W-1:0] m_hold = '0;
  logic              m_ovr = 0, m_udr = 0, lb1 = 0, lb2 = 0, c1 = 0, c2 = 0;

  always @(posedge clk) begin
    if (rst) begin
      e <= 0; m_hold <= '0; m_ovr <= 0; m_udr <= 0;
      lb1 <= 0; lb2 <= 0; c1 <= 0; c2 <= 0;
    end else begin
      e <= e + 1;
      if (e % DIV == DIV - 1 && (e / DIV) % CYC >= CYC - LAT) m_hold <= meas;
      if (e % DIV == DIV - 1 && (e / DIV) % CYC == CYC - LAT - 1) begin
        m_ovr <= ovr; m_udr <= udr;
      end
      lb1 <= lowbat; lb2 <= lb1; c1 <= cont; c2 <= c1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    int ph = (e / DIV) % CYC;
    logic exp_end = (e % DIV == DIV - 1) && (ph == CYC - 1);
    chk("R1", "cycle_end", cycle_end, exp_end);
    chk("R2", "latch_n", latch_n, (ph < CYC - LAT));
    chk("R3", "disp_value", disp_value, m_hold);
    chk("R4", "ovr_out", ovr_out, m_ovr);
    chk("R4", "udr_out", udr_out, m_udr);
    chk("R5", "digit_en", digit_en, m_ovr ? 32'h01 : 32'h1f);
    chk("R6", "ann_lowbat", ann_lowbat, lb2);
    chk("R7", "cont_out", cont_out, c2);
    chk("R7", "ann_cont", ann_cont, c2);
  endtask

  task automatic run(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      meas   = MEAS_W'(i * 7 + seed * 131 + 3);
      ovr    = ((i + seed) / 13) % 2 == 1;
      udr    = ((i + 2 * seed) / 17) % 3 == 0;
      lowbat = ((i + seed) / 11) % 2 == 1;
      cont   = ((i + seed) / 5) % 2 == 0;
    end
  endtask

  task automatic check_reset_state();
    chk("R8", "latch_n after reset", latch_n, 1);
    chk("R8", "disp_value after reset", disp_value, 0);
    chk("R8", "flags after reset", {ovr_out, udr_out}, 0);
    chk("R8", "digit_en after reset", digit_en, 32'h1f);
    chk("R8", "cycle_end after reset", cycle_end, 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    run(CYC * DIV * 6 + 7, 0);
    // Reset in the middle of a conversion, then counting restarts from count 0.
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    run(CYC * DIV * 4, 5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule